// File: doc/BRIEF.md
# Two-level DMA descriptor chain sequencer

This block is the control sequencer of one DMA channel. It walks transfer descriptors held in memory and hands each one to a separate transfer engine. Descriptors form link chains; in extended mode the link chains are themselves grouped into a chain of lists. The block fetches descriptor words one at a time over a valid/ready read port. It starts the engine with a one-cycle pulse and waits for the engine's done pulse before it follows the chain.

Software starts a run with one start pulse. The pulse carries the byte address of the first link descriptor, the address of the next list descriptor and the mode bit. A link descriptor is four words: source, destination, next-link pointer and byte count. A list descriptor is two words: next-list pointer and the first link of that list. Bit 0 of each pointer word marks the end of its chain. When a link chain ends, basic mode halts. Extended mode checks the list chain instead: it either halts or fetches the next list descriptor and carries on with that list's first link.

Top module: `dma_chain_seq`

## Requirements
- R1: While reset is held and after it is released, busy, halted, done_pulse, mem_req_valid and xfer_start are all low.
- R2: A start pulse while idle raises busy and clears halted in the following cycle. It captures start_link (low 5 bits ignored), start_list and start_ext. A start pulse while busy has no effect on the chain being walked. Memory is not read and the engine is not started while idle.
- R3: The first link descriptor is read as four words, at word addresses (start_link with low 5 bits cleared)/4 + 0, 1, 2, 3, in that order. Word 0 is the source, word 1 the destination, word 2 the next-link pointer and word 3 the byte count.
- R4: A request is held, with its address unchanged, until mem_req_ready. No new request is issued until the response beat of the previous one has arrived.
- R5: After the fourth link word arrives, xfer_start is high for exactly one cycle with xfer_src, xfer_dst and xfer_count from that descriptor. The chain advances only on xfer_done received after that pulse. An xfer_done at any other time is ignored.
- R6: On xfer_done with bit 0 of the next-link pointer clear, the next link descriptor is fetched from that pointer with its low 5 bits cleared.
- R7: On xfer_done with bit 0 of the next-link pointer set and start_ext low, the channel halts, whatever the list pointer holds.
- R8: On xfer_done with the next-link end bit set, start_ext high and bit 0 of the next-list pointer clear, the list descriptor at that pointer (low 3 bits cleared) is read as two words. Word 0 becomes the new next-list pointer. Word 1 is the first link of the new list, and that link (low 5 bits cleared) is fetched next.
- R9: In extended mode, on xfer_done with both the next-link and the next-list end bits set, the channel halts.
- R10: On halting, busy falls and halted rises in the cycle after the final xfer_done, and done_pulse is high for exactly that one cycle.
- R11: A start pulse presented in the cycle in which done_pulse is high is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start pulse for a new run |
| start_ext | input | 1 | Mode: 1 walks the list chain, 0 halts at the end of the first link chain |
| start_link | input | W | Byte address of the first link descriptor |
| start_list | input | W | Next list descriptor pointer; bit 0 is its end flag |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | W | Word address of the requested word |
| mem_rsp_valid | input | 1 | Response beat valid |
| mem_rsp_data | input | W | Response word |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |
| xfer_src | output | W | Source address of the transfer |
| xfer_dst | output | W | Destination address of the transfer |
| xfer_count | output | CNT_W | Byte count of the transfer |
| xfer_done | input | 1 | Transfer engine done pulse |
| busy | output | 1 | Channel is walking a chain |
| halted | output | 1 | Last run has finished |
| done_pulse | output | 1 | One-cycle pulse when the channel halts |

## Verification
Two things can meet in one cycle: the halt on the final xfer_done and a software start. The bench provokes this in two ways. It drives start in the very cycle of the last xfer_done, while the channel is still busy, and judges that no new fetch follows and busy stays low. It also drives start in the cycle in which done_pulse is high, and judges that busy returns at once and the new chain's descriptors are read in order. A behavioural model of busy, halted and done_pulse is compared every clock. A stray xfer_done during a fetch and a start arriving mid-chain must leave the expected read and transfer sequence unchanged.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LREQ   = 3'd1,
    ST_LWAIT  = 3'd2,
    ST_XSTART = 3'd3,
    ST_XWAIT  = 3'd4,
    ST_SREQ   = 3'd5,
    ST_SWAIT  = 3'd6
  } seq_state_t;

  localparam int LINK_WORDS = 4;
  localparam int LIST_WORDS = 2;
  localparam int IDX_W      = $clog2(LINK_WORDS);

  // word positions inside a link descriptor
  localparam logic [IDX_W-1:0] LW_SRC  = IDX_W'(0);
  localparam logic [IDX_W-1:0] LW_DST  = IDX_W'(1);
  localparam logic [IDX_W-1:0] LW_NEXT = IDX_W'(2);
  localparam logic [IDX_W-1:0] LW_CNT  = IDX_W'(3);

  // word positions inside a list descriptor
  localparam logic [IDX_W-1:0] LS_NEXT  = IDX_W'(0);
  localparam logic [IDX_W-1:0] LS_FIRST = IDX_W'(1);

  localparam logic [IDX_W-1:0] LINK_LAST = IDX_W'(LINK_WORDS - 1);
  localparam logic [IDX_W-1:0] LIST_LAST = IDX_W'(LIST_WORDS - 1);

endpackage

// File: rtl/dma_chain_rst_sync.sv
module dma_chain_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
  import dma_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_ext,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic             xfer_done,
  input  logic             eol_link,
  input  logic             eol_list,
  output logic [IDX_W-1:0] word_idx,
  output logic             mem_req_valid,
  output logic             fetch_list,
  output logic             ld_start,
  output logic             ld_link_word,
  output logic             ld_list_word,
  output logic             adv_link,
  output logic             adv_list,
  output logic             xfer_start,
  output logic             busy,
  output logic             halted,
  output logic             done_pulse
);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ext_q;
  logic             halted_q;
  logic             done_q;
  logic             halt_set;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    ld_start = 1'b0;
    adv_link = 1'b0;
    adv_list = 1'b0;
    halt_set = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_LREQ;
          idx_d    = '0;
          ld_start = 1'b1;
        end
      end
      ST_LREQ: begin
        if (mem_req_ready) state_d = ST_LWAIT;
      end
      ST_LWAIT: begin
        if (mem_rsp_valid) begin
          if (idx_q == LINK_LAST) begin
            state_d = ST_XSTART;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_LREQ;
          end
        end
      end
      ST_XSTART: state_d = ST_XWAIT;
      ST_XWAIT: begin
        if (xfer_done) begin
          adv_link = 1'b1;
          idx_d    = '0;
          if (!eol_link) begin
            state_d = ST_LREQ;
          end else if (ext_q && !eol_list) begin
            state_d  = ST_SREQ;
            adv_list = 1'b1;
          end else begin
            state_d  = ST_IDLE;
            halt_set = 1'b1;
          end
        end
      end
      ST_SREQ: begin
        if (mem_req_ready) state_d = ST_SWAIT;
      end
      ST_SWAIT: begin
        if (mem_rsp_valid) begin
          if (idx_q == LIST_LAST) begin
            idx_d   = '0;
            state_d = ST_LREQ;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_SREQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ext_q <= 1'b0;
    else if (ld_start) ext_q <= start_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    halted_q <= 1'b0;
    else if (ld_start || halt_set) halted_q <= halt_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= halt_set;
  end

  assign word_idx      = idx_q;
  assign mem_req_valid = (state_q == ST_LREQ) || (state_q == ST_SREQ);
  assign fetch_list    = (state_q == ST_SREQ) || (state_q == ST_SWAIT);
  assign ld_link_word  = (state_q == ST_LWAIT) && mem_rsp_valid;
  assign ld_list_word  = (state_q == ST_SWAIT) && mem_rsp_valid;
  assign xfer_start    = (state_q == ST_XSTART);
  assign busy          = (state_q != ST_IDLE);
  assign halted        = halted_q;
  assign done_pulse    = done_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid); // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid); // R4
  AST_XSTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start); // R5
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !halted); // R2
  AST_BUSY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !xfer_done |=> busy); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R10
  AST_HALT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> halted && !busy); // R10

endmodule

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
  import dma_chain_pkg::*;
#(
  parameter int W          = 32,
  parameter int CNT_W      = 32,
  parameter int LINK_ALIGN = 5,
  parameter int LIST_ALIGN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_start,
  input  logic [W-1:0]     start_link,
  input  logic [W-1:0]     start_list,
  input  logic             ld_link_word,
  input  logic             ld_list_word,
  input  logic [IDX_W-1:0] word_idx,
  input  logic [W-1:0]     rsp_data,
  input  logic             adv_link,
  input  logic             adv_list,
  input  logic             fetch_list,
  output logic [W-1:0]     req_word_addr,
  output logic [W-1:0]     xfer_src,
  output logic [W-1:0]     xfer_dst,
  output logic [CNT_W-1:0] xfer_count,
  output logic             eol_link,
  output logic             eol_list
);

  localparam logic [W-1:0] LINK_MASK = ~((W'(1) << LINK_ALIGN) - W'(1));
  localparam logic [W-1:0] LIST_MASK = ~((W'(1) << LIST_ALIGN) - W'(1));

  logic [W-1:0]     cur_link_q, cur_link_d;
  logic [W-1:0]     next_link_q;
  logic [W-1:0]     cur_list_q;
  logic [W-1:0]     next_list_q, next_list_d;
  logic [W-1:0]     src_q, dst_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cur_link_en, next_list_en;
  logic             src_en, dst_en, next_link_en, cnt_en;
  logic [W-1:0]     base_addr, byte_addr;

  // current link pointer: start value, chain advance, or first link of a list
  always_comb begin
    cur_link_en = ld_start || adv_link || (ld_list_word && word_idx == LS_FIRST);
    if (ld_start)      cur_link_d = start_link & LINK_MASK;
    else if (adv_link) cur_link_d = next_link_q & LINK_MASK;
    else               cur_link_d = rsp_data & LINK_MASK;
  end

  always_comb begin
    next_list_en = ld_start || (ld_list_word && word_idx == LS_NEXT);
    next_list_d  = ld_start ? start_list : rsp_data;
  end

  always_comb begin
    src_en       = ld_link_word && word_idx == LW_SRC;
    dst_en       = ld_link_word && word_idx == LW_DST;
    next_link_en = ld_link_word && word_idx == LW_NEXT;
    cnt_en       = ld_link_word && word_idx == LW_CNT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cur_link_q <= '0;
    else if (cur_link_en) cur_link_q <= cur_link_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            next_list_q <= '0;
    else if (next_list_en) next_list_q <= next_list_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cur_list_q <= '0;
    else if (adv_list) cur_list_q <= next_list_q & LIST_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            next_link_q <= '0;
    else if (next_link_en) next_link_q <= rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else begin
      if (src_en) src_q <= rsp_data;
      if (dst_en) dst_q <= rsp_data;
      if (cnt_en) cnt_q <= rsp_data[CNT_W-1:0];
    end
  end

  always_comb begin
    base_addr     = fetch_list ? cur_list_q : cur_link_q;
    byte_addr     = base_addr + W'({word_idx, 2'b00});
    req_word_addr = byte_addr >> 2;
  end

  assign xfer_src   = src_q;
  assign xfer_dst   = dst_q;
  assign xfer_count = cnt_q;
  assign eol_link   = next_link_q[0];
  assign eol_list   = next_list_q[0];

  AST_LIST_ONLY_IN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    adv_list |-> eol_link && !eol_list); // R8

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int W          = 32,
  parameter int CNT_W      = 32,
  parameter int LINK_ALIGN = 5,
  parameter int LIST_ALIGN = 3,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_ext,
  input  logic [W-1:0]     start_link,
  input  logic [W-1:0]     start_list,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [W-1:0]     mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [W-1:0]     mem_rsp_data,
  output logic             xfer_start,
  output logic [W-1:0]     xfer_src,
  output logic [W-1:0]     xfer_dst,
  output logic [CNT_W-1:0] xfer_count,
  input  logic             xfer_done,
  output logic             busy,
  output logic             halted,
  output logic             done_pulse
);

  logic             rst_sync_n;
  logic [IDX_W-1:0] word_idx;
  logic             fetch_list;
  logic             ld_start, ld_link_word, ld_list_word;
  logic             adv_link, adv_list;
  logic             eol_link, eol_list;

  dma_chain_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_chain_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .start         (start),
    .start_ext     (start_ext),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .xfer_done     (xfer_done),
    .eol_link      (eol_link),
    .eol_list      (eol_list),
    .word_idx      (word_idx),
    .mem_req_valid (mem_req_valid),
    .fetch_list    (fetch_list),
    .ld_start      (ld_start),
    .ld_link_word  (ld_link_word),
    .ld_list_word  (ld_list_word),
    .adv_link      (adv_link),
    .adv_list      (adv_list),
    .xfer_start    (xfer_start),
    .busy          (busy),
    .halted        (halted),
    .done_pulse    (done_pulse)
  );

  dma_chain_regs #(
    .W          (W),
    .CNT_W      (CNT_W),
    .LINK_ALIGN (LINK_ALIGN),
    .LIST_ALIGN (LIST_ALIGN)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .ld_start      (ld_start),
    .start_link    (start_link),
    .start_list    (start_list),
    .ld_link_word  (ld_link_word),
    .ld_list_word  (ld_list_word),
    .word_idx      (word_idx),
    .rsp_data      (mem_rsp_data),
    .adv_link      (adv_link),
    .adv_list      (adv_list),
    .fetch_list    (fetch_list),
    .req_word_addr (mem_req_addr),
    .xfer_src      (xfer_src),
    .xfer_dst      (xfer_dst),
    .xfer_count    (xfer_count),
    .eol_link      (eol_link),
    .eol_list      (eol_list)
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr)); // R4
  AST_XFER_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xfer_start |=> $stable(xfer_src) && $stable(xfer_dst) && $stable(xfer_count)); // R5

endmodule

// File: tb/dma_chain_seq_test.sv
module dma_chain_seq_test;

  localparam int W     = 32;
  localparam int CNT_W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             start, start_ext;
  logic [W-1:0]     start_link, start_list;
  logic             mem_req_valid, mem_req_ready;
  logic [W-1:0]     mem_req_addr;
  logic             mem_rsp_valid;
  logic [W-1:0]     mem_rsp_data;
  logic             xfer_start;
  logic [W-1:0]     xfer_src, xfer_dst;
  logic [CNT_W-1:0] xfer_count;
  logic             xfer_done;
  logic             busy, halted, done_pulse;

  dma_chain_seq #(.W(W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ext(start_ext),
    .start_link(start_link), .start_list(start_list),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .xfer_start(xfer_start),
    .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_count(xfer_count),
    .xfer_done(xfer_done), .busy(busy), .halted(halted), .done_pulse(done_pulse)
  );

  logic [31:0] mem [int unsigned];

  typedef struct { int unsigned addr; string tag; } exp_rd_t;
  typedef struct { logic [31:0] src; logic [31:0] dst; logic [31:0] cnt; } exp_x_t;
  exp_rd_t exp_rd[$];
  exp_x_t  exp_x[$];

  int checks = 0;
  int fails  = 0;
  int halts  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put_link(input int unsigned a, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] n, input logic [31:0] c);
    mem[a/4] = s; mem[a/4+1] = d; mem[a/4+2] = n; mem[a/4+3] = c;
  endtask

  task automatic put_list(input int unsigned a, input logic [31:0] n, input logic [31:0] f);
    mem[a/4] = n; mem[a/4+1] = f;
  endtask

  // walk the descriptor structure and queue the expected reads and transfers
  task automatic build_expect(input logic [31:0] link, input logic [31:0] lst, input bit ext);
    int unsigned cur = link & ~32'h1F;
    logic [31:0] nl = lst;
    logic [31:0] nx;
    int unsigned la;
    string t = "R3";
    for (int step = 0; step < 64; step++) begin
      for (int k = 0; k < 4; k++) exp_rd.push_back('{cur/4 + k, t});
      exp_x.push_back('{mem[cur/4], mem[cur/4+1], mem[cur/4+3]});
      nx = mem[cur/4+2];
      if (!nx[0]) begin
        cur = nx & ~32'h1F;
        t = "R6";
      end else if (!ext || nl[0]) begin
        break;
      end else begin
        la = nl & ~32'h7;
        exp_rd.push_back('{la/4, "R8"});
        exp_rd.push_back('{la/4 + 1, "R8"});
        nl  = mem[la/4];
        cur = mem[la/4+1] & ~32'h1F;
        t = "R8";
      end
    end
  endtask

  // stimulus requests from the sequence (counters, taken by the monitor)
  int          cmd_seq = 0, cmd_taken = 0;
  logic [31:0] cmd_link, cmd_list;
  bit          cmd_ext;
  int          ond_seq = 0, ond_taken = 0;
  logic [31:0] ond_link, ond_list;
  bit          ond_ext;
  bit          arm_mid = 0, arm_last = 0, arm_stray = 0;
  bit          used_mid = 0, used_last = 0, used_stray = 0;
  bit          run = 0;

  // reference model state
  bit          m_busy = 0, m_halted = 0, m_done = 0;
  bit          outst = 0;
  int          rcnt = 0;
  int unsigned raddr;
  bit          xb = 0, xlast = 0, fin;
  int          xc = 0;
  bit          r11_watch = 0;
  exp_rd_t     er;
  exp_x_t      ex;

  always @(negedge clk) begin
    if (run) begin
      // compare outputs against the model
      check(busy === m_busy, "R2", "busy", busy, m_busy);
      check(halted === m_halted, "R10", "halted", halted, m_halted);
      check(done_pulse === m_done, "R10", "done_pulse", done_pulse, m_done);
      if (!m_busy)
        check(mem_req_valid === 1'b0 && xfer_start === 1'b0, "R2", "activity while idle",
              {mem_req_valid, xfer_start}, 0);
      if (r11_watch) begin
        check(busy === 1'b1, "R11", "start during done_pulse accepted", busy, 1);
        r11_watch = 0;
      end
      if (done_pulse === 1'b1) halts++;

      // memory responder
      mem_rsp_valid = 1'b0;
      if (outst) begin
        if (rcnt <= 1) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem.exists(raddr) ? mem[raddr] : 32'h0;
          outst = 0;
        end else rcnt--;
      end
      if (mem_req_valid === 1'b1)
        check(!outst, "R4", "request while word outstanding", mem_req_valid, 0);
      mem_req_ready = ($urandom_range(0, 2) != 0);
      if (mem_req_valid === 1'b1 && mem_req_ready) begin
        if (exp_rd.size() == 0) begin
          check(0, "R3", "unexpected read", mem_req_addr, 0);
        end else begin
          er = exp_rd.pop_front();
          check(mem_req_addr === er.addr, er.tag, "read address", mem_req_addr, er.addr);
        end
        outst = 1;
        raddr = mem_req_addr;
        rcnt  = $urandom_range(1, 3);
      end

      // transfer engine
      xfer_done = 1'b0;
      fin = 0;
      if (xfer_start === 1'b1) begin
        if (exp_x.size() == 0) begin
          check(0, "R5", "unexpected transfer", xfer_src, 0);
        end else begin
          ex = exp_x.pop_front();
          check(xfer_src === ex.src, "R5", "xfer_src", xfer_src, ex.src);
          check(xfer_dst === ex.dst, "R5", "xfer_dst", xfer_dst, ex.dst);
          check(xfer_count === ex.cnt, "R5", "xfer_count", xfer_count, ex.cnt);
        end
        xb = 1;
        xc = $urandom_range(1, 4);
        xlast = (exp_x.size() == 0) && (exp_rd.size() == 0);
      end else if (xb) begin
        if (xc <= 1) begin
          xfer_done = 1'b1;
          xb  = 0;
          fin = xlast;
        end else xc--;
      end else if (arm_stray && !used_stray && mem_req_valid === 1'b1) begin
        xfer_done  = 1'b1;  // stray done during a fetch, must be ignored (R5)
        used_stray = 1;
      end

      // start requests
      start = 1'b0;
      if (fin && arm_last && !used_last) begin
        start = 1'b1; start_link = 32'h0000_9000; start_list = 32'h1; start_ext = 1'b0;
        used_last = 1;
      end else if (xfer_start === 1'b1 && arm_mid && !used_mid) begin
        start = 1'b1; start_link = 32'h0000_9000; start_list = 32'h1; start_ext = 1'b1;
        used_mid = 1;
      end else if (done_pulse === 1'b1 && ond_seq != ond_taken) begin
        start = 1'b1; start_link = ond_link; start_list = ond_list; start_ext = ond_ext;
        build_expect(ond_link, ond_list, ond_ext);
        ond_taken = ond_seq;
        r11_watch = 1;
      end else if (cmd_seq != cmd_taken && !m_busy) begin
        start = 1'b1; start_link = cmd_link; start_list = cmd_list; start_ext = cmd_ext;
        build_expect(cmd_link, cmd_list, cmd_ext);
        cmd_taken = cmd_seq;
      end

      // model update for the coming edge
      if (start && !m_busy) begin
        m_busy = 1; m_halted = 0; m_done = 0;
      end else if (fin) begin
        m_busy = 0; m_halted = 1; m_done = 1;
      end else begin
        m_done = 0;
      end
    end
  end

  task automatic issue(input logic [31:0] l, input logic [31:0] s, input bit e);
    @(posedge clk); #2;
    cmd_link = l; cmd_list = s; cmd_ext = e;
    cmd_seq++;
  endtask

  task automatic idle_check_empty(input string tag);
    repeat (3) @(negedge clk);
    #1;
    check(exp_rd.size() == 0, tag, "reads left over", exp_rd.size(), 0);
    check(exp_x.size() == 0, tag, "transfers left over", exp_x.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; start_ext = 1'b0; start_link = '0; start_list = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; xfer_done = 1'b0;

    // basic chain, pointers carry low garbage bits that must be ignored
    put_link(32'h1000, 32'hA000_0001, 32'hB000_0001, 32'h0000_105C, 32'h10);
    put_link(32'h1040, 32'hA000_0002, 32'hB000_0002, 32'h0000_1080, 32'h20);
    put_link(32'h1080, 32'hA000_0003, 32'hB000_0003, 32'h0000_0001, 32'h30);
    // list chain
    put_link(32'h3000, 32'hA100_0001, 32'hB100_0001, 32'h0000_3020, 32'h40);
    put_link(32'h3020, 32'hA100_0002, 32'hB100_0002, 32'h0000_0001, 32'h50);
    put_list(32'h4000, 32'h0000_4014, 32'h0000_3108);
    put_link(32'h3100, 32'hA200_0001, 32'hB200_0001, 32'h0000_0001, 32'h60);
    put_list(32'h4010, 32'h0000_5001, 32'h0000_3200);
    put_link(32'h3200, 32'hA300_0001, 32'hB300_0001, 32'h0000_3220, 32'h70);
    put_link(32'h3220, 32'hA300_0002, 32'hB300_0002, 32'h0000_3240, 32'h80);
    put_link(32'h3240, 32'hA300_0003, 32'hB300_0003, 32'h0000_0001, 32'h90);

    repeat (3) @(negedge clk);
    check(busy === 0 && halted === 0 && done_pulse === 0, "R1", "status in reset",
          {busy, halted, done_pulse}, 0);
    check(mem_req_valid === 0 && xfer_start === 0, "R1", "strobes in reset",
          {mem_req_valid, xfer_start}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 0 && halted === 0 && done_pulse === 0, "R1", "status after reset",
          {busy, halted, done_pulse}, 0);
    check(mem_req_valid === 0 && xfer_start === 0, "R1", "strobes after reset",
          {mem_req_valid, xfer_start}, 0);
    #1 run = 1;

    // R7: basic mode halts at end of links although list pointer is clear
    issue(32'h0000_1014, 32'h0000_2000, 1'b0);
    wait (halts == 1);
    idle_check_empty("R7");

    // R8/R9: extended mode across three lists; start during done_pulse (R11)
    ond_link = 32'h0000_3200; ond_list = 32'h0000_0001; ond_ext = 1'b1;
    ond_seq++;
    issue(32'h0000_3000, 32'h0000_4000, 1'b1);
    wait (halts == 3);
    idle_check_empty("R9");

    // R9 with end-of-lists set at start; mid-chain start, stray done, start on final done
    arm_mid = 1; arm_stray = 1; arm_last = 1;
    issue(32'h0000_1000, 32'h0000_4001, 1'b1);
    wait (halts == 4);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      check(busy === 0 && mem_req_valid === 0, "R2", "start on final done ignored",
            {busy, mem_req_valid}, 0);
    end
    idle_check_empty("R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog actual=%0d halts expected=%0d", halts, 4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule